// File: doc/BRIEF.md
# Aligned Single/Burst Packet Transfer Sequencer

This block moves one packet between a word-addressed buffer in memory and a device FIFO. A command supplies a start pointer, a word count and a direction. Receive moves FIFO words into memory. Transmit moves memory words into the FIFO. The sequencer uses single-word accesses until the pointer reaches a multiple of four. It then uses four-word bursts while at least four words of the buffer remain, and it finishes with single words.

When the transfer is over, the block raises a one-cycle completion post. The post carries a 16-bit word with an outcome code in the upper byte and masked device status in the lower byte, plus an ending word count. The outcomes are a normal end in either direction, an exactly filled receive buffer that overflowed, a zero-length command and an abort. An abort command ends any activity at once and disables the interface.

Top module: `xfer_seq`

## Requirements
- R1: While the pointer is not a multiple of four, each access is a single word. The number of leading singles follows from pointer bits [1:0]: 01 gives three, 10 gives two, 11 gives one and 00 gives none. The count is cut short if fewer words remain.
- R2: When the pointer is four-aligned and at least four words remain, the access is a burst (mem_burst=1). In receive this also needs at least four words in the FIFO, or no end condition raised. Otherwise the access is a single word. A burst address always has bits [1:0] equal to 00.
- R3: A start with count zero posts code 4 with status 0x00 and count 0, and makes no memory request.
- R4: In receive, an end condition (dev_attn=1) with the FIFO empty posts code 0. The posted count is the number of buffer words not filled; the trailing CRC word counts as a stored word. The status is dev_status AND 0x07, where bit0 is bad alignment, bit1 is CRC error and bit2 is input late. A FIFO word is popped only while receive is enabled and the FIFO is not empty.
- R5: When a receive buffer fills exactly, the block waits for one more indication. If the end condition arrives with the FIFO empty, it posts code 0 with count 0. If another word is present, it pops and discards exactly that one word and posts code 2 with count 0.
- R6: In transmit, after the last word is handed to the FIFO, tx_eop pulses for one cycle. The block then waits for dev_done or dev_attn and posts code 1 with status dev_status AND 0x18, where bit3 is output late and bit4 is collision. An end condition seen before a transfer step ends the transmit with the same post.
- R7: cmd_abort posts code 5 with status 0x60 (bit5 receive command, bit6 transmit command) on the next cycle, from any state. rx_enable and tx_enable are low whenever a post is presented.
- R8: A post is a single-cycle pulse of post_valid. post_word[15:8] holds the code and post_word[7:0] holds the masked status.
- R9: A memory request is held with a stable address until mem_gnt. A burst is one request that moves four words at consecutive addresses, in order. Receive writes the words in FIFO order, and transmit pushes them to the FIFO in memory order. No memory write occurs during transmit.
- R10: After reset, no request, pop, push, post or enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a transfer (taken when idle) |
| cmd_tx | input | 1 | Direction of the start: 1 transmit, 0 receive |
| cmd_abort | input | 1 | Abort command |
| cmd_ptr | input | AW | Buffer start address |
| cmd_count | input | CW | Buffer length in words |
| rx_enable | output | 1 | Receive path enabled |
| tx_enable | output | 1 | Transmit path enabled |
| mem_req | output | 1 | Memory request |
| mem_burst | output | 1 | Request is a four-word burst |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_gnt | input | 1 | Request accepted |
| mem_wvalid | output | 1 | Write data beat |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data beat |
| mem_rdata | input | DW | Read data |
| fifo_avail | input | LW | Receive: words present; transmit: free slots |
| fifo_rdata | input | DW | Head word of the receive FIFO |
| fifo_pop | output | 1 | Pop the receive FIFO |
| fifo_push | output | 1 | Push into the transmit FIFO |
| fifo_wdata | output | DW | Word pushed into the transmit FIFO |
| dev_attn | input | 1 | Device end/attention condition |
| dev_done | input | 1 | Device finished sending the packet |
| dev_status | input | 8 | Raw device status |
| tx_eop | output | 1 | End-of-packet control pulse |
| post_valid | output | 1 | Completion post strobe |
| post_word | output | 16 | Code (upper byte) and masked status (lower byte) |
| post_count | output | CW | Ending word count |

## Verification
The hardest case to reach is the exactly full receive buffer, because the outcome depends on what follows the last stored word. The stimulus fills the buffer exactly twice: once with the FIFO then empty and the end condition raised, and once with extra words queued, where the bench checks that only one extra word left the FIFO. The abort is sent while a receive waits on an empty FIFO, a state that holds only because the bench withholds both data and the end condition. Unaligned pointers with every nonzero low-bit value, together with a FIFO that runs below four words near the end, cover the shift from bursts back to single words.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_REQ,
    ST_BEAT,
    ST_FULL,
    ST_EOP
  } xfer_state_e;

  // completion codes, placed in the upper byte of the post word
  localparam logic [7:0] PC_IN_DONE  = 8'd0;
  localparam logic [7:0] PC_OUT_DONE = 8'd1;
  localparam logic [7:0] PC_IN_FULL  = 8'd2;
  localparam logic [7:0] PC_LOAD_OVF = 8'd3;
  localparam logic [7:0] PC_CNT_ZERO = 8'd4;
  localparam logic [7:0] PC_ABORT    = 8'd5;

  // status masks per direction
  localparam logic [7:0] RX_STAT_MASK = 8'h07; // bad align, crc, input late
  localparam logic [7:0] TX_STAT_MASK = 8'h18; // output late, collision
  localparam logic [7:0] ABORT_STAT   = 8'h60; // both command-issued bits

  localparam int unsigned BURST_WORDS = 4;

endpackage

// File: rtl/xfer_step_plan.sv
module xfer_step_plan #(
  parameter int unsigned CW = 12,
  parameter int unsigned LW = 3
) (
  input  logic [1:0]    addr_lo,
  input  logic [CW-1:0] left,
  input  logic [LW-1:0] avail,
  input  logic          is_rx,
  input  logic          dev_attn,
  output logic          use_burst,
  output logic          step_ready
);
  import xfer_pkg::*;

  localparam logic [CW-1:0] LEFT_BURST  = CW'(BURST_WORDS);
  localparam logic [LW-1:0] AVAIL_BURST = LW'(BURST_WORDS);

  logic aligned;
  logic room4;

  always_comb begin
    aligned = (addr_lo == 2'b00);
    room4   = (avail >= AVAIL_BURST);
    // a receive near its end drains leftovers singly once the device has ended
    use_burst  = aligned && (left >= LEFT_BURST) && (!is_rx || room4 || !dev_attn);
    step_ready = use_burst ? room4 : (avail != '0);
  end

endmodule

// File: rtl/xfer_post_fmt.sv
module xfer_post_fmt #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [7:0]    code,
  input  logic [7:0]    raw_status,
  input  logic [7:0]    mask,
  input  logic [CW-1:0] count_in,
  output logic          post_valid,
  output logic [15:0]   post_word,
  output logic [CW-1:0] post_count
);

  logic [15:0] word_n;

  always_comb begin
    word_n = {code, raw_status & mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_word  <= '0;
      post_count <= '0;
    end else begin
      post_valid <= fire;
      if (fire) begin
        post_word  <= word_n;
        post_count <= count_in;
      end
    end
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 12,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_tx,
  input  logic          cmd_abort,
  input  logic [AW-1:0] cmd_ptr,
  input  logic [CW-1:0] cmd_count,
  output logic          rx_enable,
  output logic          tx_enable,
  output logic          mem_req,
  output logic          mem_burst,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  output logic          mem_wvalid,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic [LW-1:0] fifo_avail,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wdata,
  input  logic          dev_attn,
  input  logic          dev_done,
  input  logic [7:0]    dev_status,
  output logic          tx_eop,
  output logic          post_valid,
  output logic [15:0]   post_word,
  output logic [CW-1:0] post_count
);
  import xfer_pkg::*;

  localparam logic [2:0]    LAST_BURST_BEAT = 3'(BURST_WORDS - 1);
  localparam logic [AW-1:0] ADDR_STEP_B     = AW'(BURST_WORDS);
  localparam logic [CW-1:0] CNT_STEP_B      = CW'(BURST_WORDS);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  xfer_state_e   st_q, st_n;
  logic          tx_q, tx_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic [CW-1:0] left_q, left_n;
  logic [2:0]    beats_q, beats_n;
  logic          burst_q, burst_n;
  logic          ctx_en;

  logic          plan_burst, plan_ready;
  logic          fire;
  logic [7:0]    fire_code, fire_raw, fire_mask;
  logic [CW-1:0] fire_cnt;
  logic          beat;

  xfer_step_plan #(.CW(CW), .LW(LW)) plan_i (
    .addr_lo    (ptr_q[1:0]),
    .left       (left_q),
    .avail      (fifo_avail),
    .is_rx      (!tx_q),
    .dev_attn   (dev_attn),
    .use_burst  (plan_burst),
    .step_ready (plan_ready)
  );

  // next-state logic
  always_comb begin
    st_n       = st_q;
    tx_n       = tx_q;
    ptr_n      = ptr_q;
    left_n     = left_q;
    beats_n    = beats_q;
    burst_n    = burst_q;
    fire       = 1'b0;
    fire_code  = PC_IN_DONE;
    fire_raw   = dev_status;
    fire_mask  = tx_q ? TX_STAT_MASK : RX_STAT_MASK;
    fire_cnt   = '0;
    mem_req    = 1'b0;
    mem_wvalid = 1'b0;
    fifo_pop   = 1'b0;
    fifo_push  = 1'b0;
    tx_eop     = 1'b0;
    beat       = 1'b0;

    if (cmd_abort) begin
      fire      = 1'b1;
      fire_code = PC_ABORT;
      fire_raw  = ABORT_STAT;
      fire_mask = 8'hFF;
      st_n      = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_start) begin
            tx_n   = cmd_tx;
            ptr_n  = cmd_ptr;
            left_n = cmd_count;
            if (cmd_count == '0) begin
              fire      = 1'b1;
              fire_code = PC_CNT_ZERO;
              fire_mask = 8'h00;
            end else begin
              st_n = ST_PICK;
            end
          end
        end
        ST_PICK: begin
          if (left_q == '0) begin
            if (tx_q) begin
              tx_eop = 1'b1;
              st_n   = ST_EOP;
            end else begin
              st_n = ST_FULL;
            end
          end else if (tx_q && dev_attn) begin
            fire      = 1'b1;
            fire_code = PC_OUT_DONE;
            st_n      = ST_IDLE;
          end else if (!tx_q && dev_attn && fifo_avail == '0) begin
            fire      = 1'b1;
            fire_code = PC_IN_DONE;
            fire_cnt  = left_q;
            st_n      = ST_IDLE;
          end else if (plan_ready) begin
            burst_n = plan_burst;
            st_n    = ST_REQ;
          end
        end
        ST_REQ: begin
          mem_req = 1'b1;
          if (mem_gnt) begin
            beats_n = burst_q ? LAST_BURST_BEAT : 3'd0;
            st_n    = ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (tx_q) begin
            beat      = mem_rvalid;
            fifo_push = mem_rvalid;
          end else begin
            beat       = 1'b1;
            mem_wvalid = 1'b1;
            fifo_pop   = 1'b1;
          end
          if (beat) begin
            if (beats_q == 3'd0) begin
              ptr_n  = ptr_q + (burst_q ? ADDR_STEP_B : AW'(1));
              left_n = left_q - (burst_q ? CNT_STEP_B : CW'(1));
              st_n   = ST_PICK;
            end else begin
              beats_n = beats_q - 3'd1;
            end
          end
        end
        ST_FULL: begin
          if (fifo_avail != '0) begin
            fifo_pop  = 1'b1;
            fire      = 1'b1;
            fire_code = PC_IN_FULL;
            st_n      = ST_IDLE;
          end else if (dev_attn) begin
            fire      = 1'b1;
            fire_code = PC_IN_DONE;
            st_n      = ST_IDLE;
          end
        end
        ST_EOP: begin
          if (dev_done || dev_attn) begin
            fire      = 1'b1;
            fire_code = PC_OUT_DONE;
            st_n      = ST_IDLE;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  // context registers only load on a start or a completed step
  assign ctx_en = (st_q == ST_IDLE && cmd_start) || (st_q == ST_BEAT) || (st_q == ST_PICK);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q    <= ST_IDLE;
      tx_q    <= 1'b0;
      ptr_q   <= '0;
      left_q  <= '0;
      beats_q <= '0;
      burst_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (ctx_en) begin
        tx_q   <= tx_n;
        ptr_q  <= ptr_n;
        left_q <= left_n;
        burst_q <= burst_n;
      end
      if (st_q == ST_REQ || st_q == ST_BEAT) begin
        beats_q <= beats_n;
      end
    end
  end

  xfer_post_fmt #(.CW(CW)) post_i (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .fire       (fire),
    .code       (fire_code),
    .raw_status (fire_raw),
    .mask       (fire_mask),
    .count_in   (fire_cnt),
    .post_valid (post_valid),
    .post_word  (post_word),
    .post_count (post_count)
  );

  assign rx_enable  = (st_q != ST_IDLE) && !tx_q;
  assign tx_enable  = (st_q != ST_IDLE) && tx_q;
  assign mem_burst  = burst_q;
  assign mem_we     = !tx_q;
  assign mem_addr   = ptr_q;
  assign mem_wdata  = fifo_rdata;
  assign fifo_wdata = mem_rdata;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12,
  parameter int unsigned LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_abort,
  input logic          rx_enable,
  input logic          tx_enable,
  input logic          mem_req,
  input logic          mem_burst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          mem_wvalid,
  input logic [LW-1:0] fifo_avail,
  input logic          fifo_pop,
  input logic          tx_eop,
  input logic          post_valid,
  input logic [15:0]   post_word
);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cmd_abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_burst)));

  assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_burst) |-> (mem_addr[1:0] == 2'b00));

  assert_post_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !cmd_abort && !cmd_start) |=> !post_valid);

  assert_abort_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (post_valid && post_word == 16'h0560));

  assert_off_at_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> (!rx_enable && !tx_enable));

  assert_eop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eop && !cmd_abort) |=> (!tx_eop && tx_enable));

  assert_pop_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rx_enable && fifo_avail != '0));

  assert_no_tx_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !tx_enable);

endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .CW(CW), .LW(LW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_abort  (cmd_abort),
  .rx_enable  (rx_enable),
  .tx_enable  (tx_enable),
  .mem_req    (mem_req),
  .mem_burst  (mem_burst),
  .mem_addr   (mem_addr),
  .mem_gnt    (mem_gnt),
  .mem_wvalid (mem_wvalid),
  .fifo_avail (fifo_avail),
  .fifo_pop   (fifo_pop),
  .tx_eop     (tx_eop),
  .post_valid (post_valid),
  .post_word  (post_word)
);

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_start, cmd_tx, cmd_abort;
  logic [AW-1:0] cmd_ptr;
  logic [CW-1:0] cmd_count;
  logic          rx_enable, tx_enable;
  logic          mem_req, mem_burst, mem_we;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt;
  logic          mem_wvalid;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata;
  logic [LW-1:0] fifo_avail;
  logic [DW-1:0] fifo_rdata;
  logic          fifo_pop, fifo_push;
  logic [DW-1:0] fifo_wdata;
  logic          dev_attn, dev_done;
  logic [7:0]    dev_status;
  logic          tx_eop;
  logic          post_valid;
  logic [15:0]   post_word;
  logic [CW-1:0] post_count;

  always #10 clk = ~clk; // 50 MHz

  xfer_seq #(.AW(AW), .DW(DW), .CW(CW), .LW(LW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;

  // bench-side models and scoreboard
  logic [15:0]   mem [0:255];
  logic [DW-1:0] rxq [$];
  logic [DW-1:0] txout [$];
  logic [16:0]   exp_txn [$];      // {burst, addr}
  logic [27:0]   exp_post [$];     // {count, word}
  logic [7:0]    rd_addr, wr_addr;
  int            rd_left = 0;
  bit            tb_tx = 1'b0;
  bit            done_pend = 1'b0;
  int            posts_seen = 0;
  int            eop_cnt = 0;
  int            stall = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_t(input logic [15:0] a, input bit b);
    exp_txn.push_back({b, a});
  endtask

  // model: drive after the falling edge, sample well before the rising edge
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; fifo_avail = '0; fifo_rdata = '0; dev_done = 0;
    forever begin
      @(negedge clk);
      if (tb_tx) fifo_avail = 3'd7;
      else       fifo_avail = (rxq.size() > 7) ? 3'd7 : 3'(rxq.size());
      fifo_rdata = (rxq.size() > 0) ? rxq[0] : '0;
      stall++;
      mem_gnt    = mem_req && stall[0];
      mem_rvalid = (rd_left > 0);
      mem_rdata  = mem[rd_addr];
      dev_done   = done_pend;
      done_pend  = 1'b0;
      #5;
      if (rst_n) begin
        if (fifo_pop) begin
          if (rxq.size() == 0) chk(1'b0, "R4 pop from empty fifo", 1, 0);
          else void'(rxq.pop_front());
        end
        if (fifo_push) txout.push_back(fifo_wdata);
        if (mem_wvalid) begin mem[wr_addr] = mem_wdata; wr_addr++; end
        if (mem_rvalid) begin rd_addr++; rd_left--; end
        if (mem_req && mem_gnt) begin
          if (exp_txn.size() == 0) chk(1'b0, "R1/R2 unexpected request", {15'd0, mem_burst, mem_addr}, 0);
          else begin
            logic [16:0] e;
            e = exp_txn.pop_front();
            chk({mem_burst, mem_addr} == e, "R1/R2 request order", {15'd0, mem_burst, mem_addr}, {15'd0, e});
          end
          if (!mem_we) begin rd_addr = mem_addr[7:0]; rd_left = mem_burst ? 4 : 1; end
          else wr_addr = mem_addr[7:0];
        end
        if (tx_eop) begin done_pend = 1'b1; eop_cnt++; end
        if (post_valid) begin
          posts_seen++;
          if (exp_post.size() == 0) chk(1'b0, "R8 unexpected post", {4'd0, post_count, post_word}, 0);
          else begin
            logic [27:0] p;
            p = exp_post.pop_front();
            chk({post_count, post_word} == p, "R8 post word/count", {4'd0, post_count, post_word}, {4'd0, p});
          end
        end
      end
    end
  end

  task automatic wait_post(input int target);
    int n = 0;
    while (posts_seen < target && n < 500) begin @(posedge clk); n++; end
    chk(posts_seen >= target, "post arrived", posts_seen, target);
    repeat (3) @(negedge clk);
    chk(exp_txn.size() == 0, "R1/R2 all requests issued", exp_txn.size(), 0);
  endtask

  task automatic start(input bit tx, input logic [15:0] p, input logic [11:0] c);
    @(negedge clk);
    tb_tx = tx;
    cmd_tx = tx; cmd_ptr = p; cmd_count = c; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  int base;

  initial begin
    rst_n = 0; cmd_start = 0; cmd_tx = 0; cmd_abort = 0; cmd_ptr = '0; cmd_count = '0;
    dev_attn = 0; dev_status = '0;
    rd_addr = '0; wr_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mem_req && !fifo_pop && !fifo_push && !post_valid && !rx_enable && !tx_enable,
        "R10 reset outputs", {mem_req, fifo_pop, fifo_push, post_valid, rx_enable, tx_enable}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!mem_req && !post_valid && !rx_enable, "R10 idle after release", {mem_req, post_valid, rx_enable}, 0);

    // R3 zero count
    base = posts_seen;
    exp_post.push_back({12'd0, 16'h0400});
    start(1'b0, 16'h0010, 12'd0);
    wait_post(base + 1);

    // R1 R2 R4 receive, low bits 01, ends early
    base = posts_seen;
    for (int i = 0; i < 10; i++) rxq.push_back(16'hA000 + 16'(i));
    dev_attn = 1; dev_status = 8'hFF;
    exp_t(16'h21,0); exp_t(16'h22,0); exp_t(16'h23,0); exp_t(16'h24,1);
    exp_t(16'h28,0); exp_t(16'h29,0); exp_t(16'h2A,0);
    exp_post.push_back({12'd10, 16'h0007});
    start(1'b0, 16'h0021, 12'd20);
    wait_post(base + 1);
    for (int i = 0; i < 10; i++)
      chk(mem[8'h21 + i] == 16'hA000 + 16'(i), "R9 rx data order", mem[8'h21 + i], 16'hA000 + 16'(i));

    // R5 exact fill then end
    base = posts_seen;
    for (int i = 0; i < 8; i++) rxq.push_back(16'hB000 + 16'(i));
    dev_status = 8'h02;
    exp_t(16'h40,1); exp_t(16'h44,1);
    exp_post.push_back({12'd0, 16'h0002});
    start(1'b0, 16'h0040, 12'd8);
    wait_post(base + 1);
    chk(mem[8'h47] == 16'hB007, "R9 burst last word", mem[8'h47], 16'hB007);

    // R5 exact fill then one extra word: overflow
    base = posts_seen;
    for (int i = 0; i < 9; i++) rxq.push_back(16'hC000 + 16'(i));
    dev_status = 8'h04;
    exp_t(16'h52,0); exp_t(16'h53,0); exp_t(16'h54,1);
    exp_post.push_back({12'd0, 16'h0204});
    start(1'b0, 16'h0052, 12'd6);
    wait_post(base + 1);
    chk(rxq.size() == 2, "R5 exactly one word discarded", rxq.size(), 2);
    chk(mem[8'h58] == 16'h0000, "R5 discarded word not stored", mem[8'h58], 0);
    rxq.delete();

    // R1 with low bits 10, R4 remaining count
    base = posts_seen;
    for (int i = 0; i < 3; i++) rxq.push_back(16'hE000 + 16'(i));
    dev_status = 8'h01;
    exp_t(16'hB2,0); exp_t(16'hB3,0); exp_t(16'hB4,0);
    exp_post.push_back({12'd9, 16'h0001});
    start(1'b0, 16'h00B2, 12'd12);
    wait_post(base + 1);

    // R2 aligned receive, burst then trailing single
    base = posts_seen;
    for (int i = 0; i < 5; i++) rxq.push_back(16'hF000 + 16'(i));
    dev_status = 8'h00;
    exp_t(16'hA0,1); exp_t(16'hA4,0);
    exp_post.push_back({12'd0, 16'h0000});
    start(1'b0, 16'h00A0, 12'd5);
    wait_post(base + 1);
    chk(mem[8'hA4] == 16'hF004, "R2 trailing single data", mem[8'hA4], 16'hF004);

    // R6 R1 transmit, low bits 11
    base = posts_seen;
    dev_attn = 0; dev_status = 8'hFF;
    for (int i = 0; i < 9; i++) mem[8'h63 + i] = 16'hD000 + 16'(i);
    txout.delete();
    exp_t(16'h63,0); exp_t(16'h64,1); exp_t(16'h68,1);
    exp_post.push_back({12'd0, 16'h0118});
    start(1'b1, 16'h0063, 12'd9);
    wait_post(base + 1);
    chk(eop_cnt == 1, "R6 one eop pulse", eop_cnt, 1);
    chk(txout.size() == 9, "R9 tx word count", txout.size(), 9);
    for (int i = 0; i < 9 && i < txout.size(); i++)
      chk(txout[i] == 16'hD000 + 16'(i), "R9 tx data order", txout[i], 16'hD000 + 16'(i));

    // R2 short aligned transmit uses singles
    base = posts_seen;
    dev_status = 8'h09;
    exp_t(16'h70,0); exp_t(16'h71,0); exp_t(16'h72,0);
    exp_post.push_back({12'd0, 16'h0108});
    start(1'b1, 16'h0070, 12'd3);
    wait_post(base + 1);
    chk(eop_cnt == 2, "R6 eop after short transmit", eop_cnt, 2);

    // R6 transmit ended by attention before any step
    base = posts_seen;
    dev_attn = 1; dev_status = 8'h10;
    exp_post.push_back({12'd0, 16'h0110});
    start(1'b1, 16'h0090, 12'd8);
    wait_post(base + 1);
    chk(eop_cnt == 2, "R6 no eop on attention", eop_cnt, 2);

    // R7 abort while receive waits on an empty fifo
    base = posts_seen;
    dev_attn = 0;
    start(1'b0, 16'h0080, 12'd4);
    repeat (5) @(negedge clk);
    chk(rx_enable && posts_seen == base, "R7 receive waiting", {rx_enable, 8'(posts_seen - base)}, 9'h100);
    exp_post.push_back({12'd0, 16'h0560});
    cmd_abort = 1'b1;
    @(negedge clk);
    cmd_abort = 1'b0;
    wait_post(base + 1);
    chk(!rx_enable && !tx_enable, "R7 interface disabled", {rx_enable, tx_enable}, 0);

    chk(exp_post.size() == 0, "R8 all posts seen", exp_post.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule